// File: doc/BRIEF.md
# ADC Output Test-Pattern Generator

This block sits between a dual 8-bit converter and its four output ports. The ports form two pairs: the A pair (`out_ai`, `out_aq`) and the B pair (`out_bi`, `out_bq`). In normal operation it passes the converted samples through. When the test function is switched on, it replaces them with a known pattern so that the board-level I/O can be checked without a clean analog input. The pattern is either a fixed byte or a free-running ramp. In both cases the two pairs carry bitwise-complementary data.

A 16-bit control word arrives in parallel on the configuration clock and takes effect only when a load strobe is given. The I ports (`out_ai`, `out_bi`) are registered on `clk_i` and the Q ports (`out_aq`, `out_bq`) on `clk_q`. Each channel domain takes the configuration through a two-flop synchronised toggle and then captures the held word. Each channel keeps its own ramp counter, so a ramp advances only while that channel's clock runs.

Control word fields:
- bit 0 enables the test function.
- bit 1 selects dynamic (1) or static (0).
- bits 9..2 hold the static byte.
- bits 15..10 are ignored.

Top module: `adc_pattern_gen`

## Requirements
- R1: While `rst_n` is low, all four outputs read 0.
- R2: With control bit 0 at 0, each output equals its own `adc_*` input as sampled one edge earlier on that port's channel clock.
- R3: With bits 1..0 = 01, `out_bi` and `out_bq` show control bits 9..2 as a byte.
- R4: With bits 1..0 = 01, `out_ai` and `out_aq` show the bitwise inverse of control bits 9..2.
- R5: With bits 1..0 = 11, `out_bi` and `out_bq` increase by one on every edge of their channel clock, wrapping from 255 to 0.
- R6: With bits 1..0 = 11, `out_ai`/`out_aq` are the bitwise inverse of `out_bi`/`out_bq`, so they count down and wrap from 0 to 255.
- R7: On entering dynamic mode, the first ramp value is 0 on the B ports and 255 on the A ports.
- R8: Control bits 15..10 have no effect on any output.
- R9: A change of `cfg_word` without a `cfg_load` pulse has no effect on any output.
- R10: The I ports advance only on `clk_i` and the Q ports only on `clk_q`. A stopped `clk_q` freezes `out_aq`/`out_bq` while the I ramp keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration clock |
| clk_i | input | 1 | I channel clock |
| clk_q | input | 1 | Q channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 16 | Control word |
| cfg_load | input | 1 | Load strobe for `cfg_word`, on `cfg_clk` |
| adc_ai | input | 8 | Converter data, A pair, I channel |
| adc_aq | input | 8 | Converter data, A pair, Q channel |
| adc_bi | input | 8 | Converter data, B pair, I channel |
| adc_bq | input | 8 | Converter data, B pair, Q channel |
| out_ai | output | 8 | Output port, A pair, I channel |
| out_aq | output | 8 | Output port, A pair, Q channel |
| out_bi | output | 8 | Output port, B pair, I channel |
| out_bq | output | 8 | Output port, B pair, Q channel |

## Verification
The clocked properties rely on two assumptions about the inputs:
- Loads are spaced further apart than the synchroniser latency of the slower channel, so a channel captures the held word only while it is stable.
- Each channel clock is either running or stopped, never glitching.

The stimulus honours this by waiting fourteen configuration cycles after every strobe, which covers several `clk_q` periods. It stops `clk_q` only while no load is pending. The properties also skip the first two channel edges after reset, so that no `$past` value reaches back into the reset period.

// File: rtl/adc_pattern_gen.sv
module adc_pattern_gen #(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          cfg_clk,
  input  logic          clk_i,
  input  logic          clk_q,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_word,
  input  logic          cfg_load,
  input  logic [DW-1:0] adc_ai,
  input  logic [DW-1:0] adc_aq,
  input  logic [DW-1:0] adc_bi,
  input  logic [DW-1:0] adc_bq,
  output logic [DW-1:0] out_ai,
  output logic [DW-1:0] out_aq,
  output logic [DW-1:0] out_bi,
  output logic [DW-1:0] out_bq
);
  localparam int KW = DW + 2;

  logic [KW-1:0]   hold;
  logic            tgl;
  logic [2*KW-1:0] cfg_all;
  logic [2*DW-1:0] a_all, b_all;
  logic            unused_cfg_hi;

  assign unused_cfg_hi = ^cfg_word[CW-1:KW];

  always_ff @(posedge cfg_clk or negedge rst_n)
    if (!rst_n) begin
      hold <= '0;
      tgl  <= 1'b0;
    end else if (cfg_load) begin
      hold <= cfg_word[KW-1:0];
      tgl  <= ~tgl;
    end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic          clk;
    logic [DW-1:0] a_in, b_in, ramp, a_q, b_q;
    logic [2:0]    sy;
    logic [KW-1:0] cfg;
    logic          act, dyn;
    logic [DW-1:0] pat;

    assign clk  = (c == 0) ? clk_i  : clk_q;
    assign a_in = (c == 0) ? adc_ai : adc_aq;
    assign b_in = (c == 0) ? adc_bi : adc_bq;
    assign act  = cfg[0];
    assign dyn  = cfg[0] & cfg[1];
    assign pat  = cfg[KW-1:2];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sy  <= '0;
        cfg <= '0;
      end else begin
        sy <= {sy[1:0], tgl};
        if (sy[2] ^ sy[1]) cfg <= hold;
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   ramp <= '0;
      else if (dyn) ramp <= ramp + 1'b1;
      else          ramp <= '0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        a_q <= '0;
        b_q <= '0;
      end else begin
        b_q <= !act ? b_in : (dyn ? ramp  : pat);
        a_q <= !act ? a_in : (dyn ? ~ramp : ~pat);
      end

    assign cfg_all[c*KW +: KW] = cfg;
    assign a_all[c*DW +: DW]   = a_q;
    assign b_all[c*DW +: DW]   = b_q;
  end

  assign out_ai = a_all[DW-1:0];
  assign out_aq = a_all[2*DW-1:DW];
  assign out_bi = b_all[DW-1:0];
  assign out_bq = b_all[2*DW-1:DW];
endmodule

// File: rtl/adc_pattern_gen_chk.sv
module adc_pattern_gen_chk #(
  parameter int DW = 8,
  parameter int KW = DW + 2
) (
  input logic            clk_i,
  input logic            clk_q,
  input logic            rst_n,
  input logic [2*KW-1:0] cfg_all,
  input logic [DW-1:0]   adc_ai,
  input logic [DW-1:0]   adc_aq,
  input logic [DW-1:0]   adc_bi,
  input logic [DW-1:0]   adc_bq,
  input logic [DW-1:0]   out_ai,
  input logic [DW-1:0]   out_aq,
  input logic [DW-1:0]   out_bi,
  input logic [DW-1:0]   out_bq
);
  logic [1:0] arm_i, arm_q;
  logic act_i, dyn_i, act_q, dyn_q;
  logic [DW-1:0] pat_i, pat_q;

  assign act_i = cfg_all[0];
  assign dyn_i = cfg_all[0] & cfg_all[1];
  assign pat_i = cfg_all[KW-1:2];
  assign act_q = cfg_all[KW];
  assign dyn_q = cfg_all[KW] & cfg_all[KW+1];
  assign pat_q = cfg_all[2*KW-1:KW+2];

  always_ff @(posedge clk_i or negedge rst_n)
    if (!rst_n) arm_i <= '0; else arm_i <= {arm_i[0], 1'b1};
  always_ff @(posedge clk_q or negedge rst_n)
    if (!rst_n) arm_q <= '0; else arm_q <= {arm_q[0], 1'b1};

  assert_pass_i_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (arm_i[1] && !$past(act_i)) |-> (out_bi == $past(adc_bi) && out_ai == $past(adc_ai)));
  assert_pass_q_R2: assert property (@(posedge clk_q) disable iff (!rst_n)
    (arm_q[1] && !$past(act_q)) |-> (out_bq == $past(adc_bq) && out_aq == $past(adc_aq)));
  assert_static_i_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (arm_i[1] && $past(act_i && !dyn_i)) |-> out_bi == $past(pat_i));
  assert_static_q_R3: assert property (@(posedge clk_q) disable iff (!rst_n)
    (arm_q[1] && $past(act_q && !dyn_q)) |-> out_bq == $past(pat_q));
  assert_inverse_i_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (arm_i[1] && $past(act_i)) |-> out_ai == ~out_bi);
  assert_inverse_q_R6: assert property (@(posedge clk_q) disable iff (!rst_n)
    (arm_q[1] && $past(act_q)) |-> out_aq == ~out_bq);
  assert_step_i_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (arm_i[1] && $past(dyn_i) && $past(dyn_i, 2)) |-> out_bi == $past(out_bi) + 1'b1);
  assert_step_q_R5: assert property (@(posedge clk_q) disable iff (!rst_n)
    (arm_q[1] && $past(dyn_q) && $past(dyn_q, 2)) |-> out_bq == $past(out_bq) + 1'b1);
  assert_start_i_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (arm_i[1] && $past(dyn_i) && !$past(dyn_i, 2)) |-> out_bi == '0);
  assert_start_q_R7: assert property (@(posedge clk_q) disable iff (!rst_n)
    (arm_q[1] && $past(dyn_q) && !$past(dyn_q, 2)) |-> out_bq == '0);
endmodule

bind adc_pattern_gen adc_pattern_gen_chk #(.DW(DW), .KW(KW)) u_chk (.*);

// File: tb/test_adc_pattern_gen.sv
module test_adc_pattern_gen;
  logic clk = 1'b0, clk_q = 1'b0, q_run = 1'b1, rst_n = 1'b0;
  logic [15:0] cfg_word = '0;
  logic cfg_load = 1'b0;
  logic [7:0] adc_ai = 8'hA5, adc_aq = 8'h5A, adc_bi = 8'h3C, adc_bq = 8'hC3;
  logic [7:0] out_ai, out_aq, out_bi, out_bq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always #7 if (q_run) clk_q = ~clk_q;

  adc_pattern_gen i_adc_pattern_gen (
    .cfg_clk(clk), .clk_i(clk), .clk_q(clk_q), .rst_n(rst_n),
    .cfg_word(cfg_word), .cfg_load(cfg_load),
    .adc_ai(adc_ai), .adc_aq(adc_aq), .adc_bi(adc_bi), .adc_bq(adc_bq),
    .out_ai(out_ai), .out_aq(out_aq), .out_bi(out_bi), .out_bq(out_bq));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic strobe(input logic [15:0] w);
    @(negedge clk); cfg_word = w; cfg_load = 1'b1;
    @(negedge clk); cfg_load = 1'b0;
  endtask

  task automatic load(input logic [15:0] w);
    strobe(w);
    repeat (14) @(negedge clk);
  endtask

  task automatic ramp_i();
    logic [7:0] prev;
    int n = 0;
    while (out_bi == 8'h3C && n < 60) begin @(negedge clk); n++; end
    chk("R7 bi start", out_bi, 8'h00);
    chk("R7 ai start", out_ai, 8'hFF);
    repeat (600) begin
      prev = out_bi;
      @(negedge clk);
      chk("R5 bi step", out_bi, prev + 8'd1);
      chk("R6 ai inverse", out_ai, ~out_bi);
    end
  endtask

  task automatic ramp_q();
    logic [7:0] prev;
    int n = 0;
    while (out_bq == 8'h3C && n < 60) begin @(negedge clk_q); n++; end
    chk("R7 bq start", out_bq, 8'h00);
    chk("R7 aq start", out_aq, 8'hFF);
    repeat (400) begin
      prev = out_bq;
      @(negedge clk_q);
      chk("R5 bq step", out_bq, prev + 8'd1);
      chk("R6 aq inverse", out_aq, ~out_bq);
    end
  endtask

  initial begin
    logic [7:0] snap_q, snap_i;
    repeat (3) @(negedge clk);
    chk("R1 ai", out_ai, 8'h00); chk("R1 aq", out_aq, 8'h00);
    chk("R1 bi", out_bi, 8'h00); chk("R1 bq", out_bq, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < 256; v++) begin
      adc_bi = 8'(v); adc_ai = 8'(v) ^ 8'h5F;
      @(negedge clk);
      chk("R2 bi", out_bi, 8'(v)); chk("R2 ai", out_ai, 8'(v) ^ 8'h5F);
    end
    @(negedge clk_q);
    for (int v = 0; v < 256; v++) begin
      adc_bq = 8'(v * 3 + 1); adc_aq = ~8'(v);
      @(negedge clk_q);
      chk("R2 bq", out_bq, 8'(v * 3 + 1)); chk("R2 aq", out_aq, ~8'(v));
    end

    for (int p = 0; p < 256; p++) begin
      load({6'(p) ^ 6'h15, 8'(p), 2'b01});
      chk("R3 bi", out_bi, 8'(p)); chk("R3 bq", out_bq, 8'(p));
      chk("R4 ai", out_ai, ~8'(p)); chk("R4 aq", out_aq, ~8'(p));
    end

    for (int p = 0; p < 4; p++) begin
      load({6'h00, 8'(p * 77), 2'b01});
      snap_i = out_bi;
      load({6'h3F, 8'(p * 77), 2'b01});
      chk("R8 bi", out_bi, snap_i); chk("R8 aq", out_aq, ~snap_i);
    end

    load({6'h00, 8'h3C, 2'b01});
    @(negedge clk); cfg_word = {6'h00, 8'h81, 2'b11};
    repeat (20) @(negedge clk);
    chk("R9 bi", out_bi, 8'h3C); chk("R9 bq", out_bq, 8'h3C);
    chk("R9 ai", out_ai, 8'hC3);

    strobe({6'h00, 8'h81, 2'b11});
    fork
      ramp_i();
      ramp_q();
    join

    q_run = 1'b0;
    repeat (2) @(negedge clk);
    snap_q = out_bq; snap_i = out_bi;
    repeat (30) @(negedge clk);
    chk("R10 bq frozen", out_bq, snap_q);
    chk("R10 bi runs", out_bi, snap_i + 8'd30);
    q_run = 1'b1;
    repeat (5) @(negedge clk_q);
    snap_q = out_bq;
    @(negedge clk_q);
    chk("R10 bq resumes", out_bq, snap_q + 8'd1);

    load(16'h0000);
    adc_bi = 8'h6E; adc_ai = 8'h17;
    @(negedge clk);
    chk("R2 bi after test", out_bi, 8'h6E); chk("R2 ai after test", out_ai, 8'h17);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule